// File: doc/BRIEF.md
# Retired-Instruction Counter CSR Unit

This block keeps one 64-bit count of retired instructions and presents it through the control-register address space. The cycle and instret addresses both read and write this same count. The block serves single-cycle reads and writes. The read result and an illegal-access flag are combinational from the request. Writes take effect at the next rising clock edge.

Reads of the user-level copies are gated by two 32-bit counter-enable registers, one held by the machine level and one by the supervisor level. On a core running in 32-bit mode, the count is reached as a low half and a high half. In 64-bit mode it is reached as one value. The performance-counter slots that have no counter behind them, and their event selectors, read as zero.

The core feeds in a retire pulse, its current privilege level and its XLEN mode. It issues CSR accesses with a 12-bit address and receives the data or an illegal indication. When an access is illegal, the core raises its own trap.

Top module: `csr_ctr_unit`

## Requirements
- R1: After a synchronous active-high reset, the counter, the machine enable register (address 0x306) and the supervisor enable register (address 0x106) all read as zero.
- R2: Each cycle with `retire` high raises the counter by one, unless a legal counter write lands in the same cycle. A cycle without `retire` and without a counter write leaves the counter unchanged.
- R3: A legal write to the counter in the same cycle as `retire` stores the written value and applies no increment.
- R4: With `xlen32`=1, a write to 0xB00 or 0xB02 replaces bits 31:0 and keeps bits 63:32. A write to 0xB80 or 0xB82 replaces bits 63:32 with `csr_wdata[31:0]` and keeps bits 31:0. Reads of 0xB00, 0xB02, 0xC00 and 0xC02 return bits 31:0 zero-extended, and reads of 0xB80, 0xB82, 0xC80 and 0xC82 return bits 63:32.
- R5: With `xlen32`=0, a write to 0xB00 or 0xB02 replaces all 64 bits, and reads return all 64 bits. Every high-half address (0xB81 to 0xB9F except 0xB81, 0xC80 to 0xC9F except 0xC81, and 0xB80) is illegal in this mode.
- R6: Privilege is encoded U=0, S=1, M=3. The effective enable is all ones at M. Below M it is ANDed with the machine enable register, and at U it is also ANDed with the supervisor enable register. A user-level address 0xC00..0xC1F or 0xC80..0xC9F, except offset 1, is permitted when bit `addr[4:0]` of the effective enable is set. Machine-level counter addresses are always permitted.
- R7: A denied read, or any access to an address the block does not serve (including 0xC01 and 0xC81), raises `csr_illegal`, and `csr_rdata` is zero.
- R8: The performance-counter slots 3 to 31 (user 0xC03..0xC1F, machine 0xB03..0xB1F, and their high halves in 32-bit mode) and the event selectors 0x323..0x33F read as zero when legal.
- R9: Both enable registers are 32 bits wide. A write stores `csr_wdata[31:0]`, and a read returns that value zero-extended. A write to an enable register does not block a same-cycle increment.
- R10: The user-level addresses are read-only. A write to them raises `csr_illegal` and changes neither the counter nor the enable registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 12 | CSR address of the access |
| csr_rd | input | 1 | Read strobe |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | 64 | Write data |
| retire | input | 1 | One instruction retired this cycle |
| priv | input | 2 | Current privilege (U=0, S=1, M=3) |
| xlen32 | input | 1 | 1: 32-bit mode, 0: 64-bit mode |
| csr_rdata | output | 64 | Read data, zero when not a legal read |
| csr_illegal | output | 1 | Access is denied or unsupported |

## Verification
The bench builds the block with its default parameters: a 64-bit counter and 32 enable bits. At that size the whole user-level window can be swept, which covers all 64 low and high addresses. The sweep runs under every privilege code and both XLEN modes, against sixteen pairings of enable patterns. This brings every permission bit position, and every AND-layering case between the two enable registers, within reach. Directed cycles then collide writes with retire pulses in both modes, so that write precedence and half preservation are checked against a counter preloaded with a distinct pattern.

// File: rtl/csr_ctr_pkg.sv
package csr_ctr_pkg;

    localparam int ADDR_W = 12;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam logic [ADDR_W-1:0] ADDR_MEN = 12'h306;
    localparam logic [ADDR_W-1:0] ADDR_SEN = 12'h106;

    // upper seven address bits of each 32-entry window
    localparam logic [6:0] WIN_USER_LO = 7'h60;   // 0xC00
    localparam logic [6:0] WIN_USER_HI = 7'h64;   // 0xC80
    localparam logic [6:0] WIN_MACH_LO = 7'h58;   // 0xB00
    localparam logic [6:0] WIN_MACH_HI = 7'h5C;   // 0xB80
    localparam logic [6:0] WIN_EVENT   = 7'h19;   // 0x320

    typedef enum logic [3:0] {
        CLS_NONE,
        CLS_UCNT,
        CLS_UCNT_HI,
        CLS_UHPM,
        CLS_UHPM_HI,
        CLS_MCNT,
        CLS_MCNT_HI,
        CLS_MHPM,
        CLS_MHPM_HI,
        CLS_EVENT,
        CLS_MEN,
        CLS_SEN
    } acc_class_e;

    typedef struct packed {
        acc_class_e cls;
        logic [4:0] slot;
    } csr_decode_t;

    typedef struct packed {
        logic rd_ok;
        logic wr_ok;
    } acc_rights_t;

    function automatic acc_class_e classify(input logic [ADDR_W-1:0] a);
        logic [4:0] s;
        logic       is_cnt;
        logic       is_hpm;
        s      = a[4:0];
        is_cnt = (s == 5'd0) || (s == 5'd2);
        is_hpm = (s >= 5'd3);
        if (a == ADDR_MEN)
            return CLS_MEN;
        if (a == ADDR_SEN)
            return CLS_SEN;
        case (a[ADDR_W-1:5])
            WIN_USER_LO: return is_cnt ? CLS_UCNT    : (is_hpm ? CLS_UHPM    : CLS_NONE);
            WIN_USER_HI: return is_cnt ? CLS_UCNT_HI : (is_hpm ? CLS_UHPM_HI : CLS_NONE);
            WIN_MACH_LO: return is_cnt ? CLS_MCNT    : (is_hpm ? CLS_MHPM    : CLS_NONE);
            WIN_MACH_HI: return is_cnt ? CLS_MCNT_HI : (is_hpm ? CLS_MHPM_HI : CLS_NONE);
            WIN_EVENT:   return is_hpm ? CLS_EVENT : CLS_NONE;
            default:     return CLS_NONE;
        endcase
    endfunction

endpackage

// File: rtl/csr_ctr_decode.sv
module csr_ctr_decode
    import csr_ctr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output csr_decode_t       dec
);
    always_comb begin
        dec.cls  = classify(addr);
        dec.slot = addr[4:0];
    end
endmodule

// File: rtl/csr_ctr_gate.sv
module csr_ctr_gate
    import csr_ctr_pkg::*;
#(
    parameter int EN_W = 32,
    localparam int IDX_W = $clog2(EN_W)
) (
    input  logic [1:0]      priv,
    input  logic [EN_W-1:0] men,
    input  logic [EN_W-1:0] sen,
    input  logic [IDX_W-1:0] slot,
    output logic            permit
);
    logic [EN_W-1:0] eff;

    always_comb begin
        eff = '1;
        if (priv != PRIV_M)
            eff = eff & men;
        if (priv == PRIV_U)
            eff = eff & sen;
        permit = eff[slot];
    end
endmodule

// File: rtl/csr_ctr_store.sv
module csr_ctr_store #(
    parameter int CNT_W = 64,
    parameter int EN_W  = 32,
    localparam int HALF = CNT_W / 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_full,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic             wr_men,
    input  logic             wr_sen,
    input  logic [CNT_W-1:0] wdata,
    input  logic             retire,
    output logic [CNT_W-1:0] cnt,
    output logic [EN_W-1:0]  men,
    output logic [EN_W-1:0]  sen
);
    logic cnt_touch;
    assign cnt_touch = wr_full | wr_lo | wr_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (wr_full) begin
            cnt <= wdata;
        end else if (wr_lo) begin
            cnt[HALF-1:0] <= wdata[HALF-1:0];
        end else if (wr_hi) begin
            cnt[CNT_W-1:HALF] <= wdata[HALF-1:0];
        end else if (retire) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            men <= '0;
            sen <= '0;
        end else begin
            if (wr_men) men <= wdata[EN_W-1:0];
            if (wr_sen) sen <= wdata[EN_W-1:0];
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cnt == '0 && men == '0 && sen == '0)); // R1
    AST_RETIRE_STEP: assert property (@(posedge clk) disable iff (rst)
        (retire && !cnt_touch) |=> cnt == $past(cnt) + CNT_W'(1)); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!retire && !cnt_touch) |=> $stable(cnt)); // R2
    AST_WRITE_BEATS_RETIRE: assert property (@(posedge clk) disable iff (rst)
        wr_full |=> cnt == $past(wdata)); // R3
    AST_HIGH_WRITE_KEEPS_LOW: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> cnt[HALF-1:0] == $past(cnt[HALF-1:0])); // R4
    AST_LOW_WRITE_KEEPS_HIGH: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> cnt[CNT_W-1:HALF] == $past(cnt[CNT_W-1:HALF])); // R4
endmodule

// File: rtl/csr_ctr_unit.sv
module csr_ctr_unit
    import csr_ctr_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int EN_W   = 32,
    localparam int HALF  = DATA_W / 2,
    localparam int IDX_W = $clog2(EN_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic              csr_rd,
    input  logic              csr_wr,
    input  logic [DATA_W-1:0] csr_wdata,
    input  logic              retire,
    input  logic [1:0]        priv,
    input  logic              xlen32,
    output logic [DATA_W-1:0] csr_rdata,
    output logic              csr_illegal
);
    csr_decode_t       dec;
    acc_rights_t       rights;
    logic              permit;
    logic [DATA_W-1:0] cnt;
    logic [EN_W-1:0]   men;
    logic [EN_W-1:0]   sen;
    logic [DATA_W-1:0] low_view;
    logic [DATA_W-1:0] high_view;
    logic [DATA_W-1:0] value;
    logic              wr_go;
    logic              wr_full;
    logic              wr_lo;
    logic              wr_hi;
    logic              wr_men;
    logic              wr_sen;

    csr_ctr_decode u_decode (
        .addr (csr_addr),
        .dec  (dec)
    );

    csr_ctr_gate #(.EN_W(EN_W)) u_gate (
        .priv   (priv),
        .men    (men),
        .sen    (sen),
        .slot   (dec.slot[IDX_W-1:0]),
        .permit (permit)
    );

    assign low_view  = xlen32 ? {{HALF{1'b0}}, cnt[HALF-1:0]} : cnt;
    assign high_view = {{HALF{1'b0}}, cnt[DATA_W-1:HALF]};

    always_comb begin
        rights = '0;
        value  = '0;
        unique case (dec.cls)
            CLS_UCNT:    begin rights.rd_ok = permit;          value = low_view;  end
            CLS_UCNT_HI: begin rights.rd_ok = permit & xlen32; value = high_view; end
            CLS_UHPM:    begin rights.rd_ok = permit;                            end
            CLS_UHPM_HI: begin rights.rd_ok = permit & xlen32;                   end
            CLS_MCNT:    begin rights = '{1'b1, 1'b1};         value = low_view;  end
            CLS_MCNT_HI: begin rights = '{xlen32, xlen32};     value = high_view; end
            CLS_MHPM:    begin rights = '{1'b1, 1'b1};                           end
            CLS_MHPM_HI: begin rights = '{xlen32, xlen32};                       end
            CLS_EVENT:   begin rights = '{1'b1, 1'b1};                           end
            CLS_MEN:     begin rights = '{1'b1, 1'b1}; value = {{(DATA_W-EN_W){1'b0}}, men}; end
            CLS_SEN:     begin rights = '{1'b1, 1'b1}; value = {{(DATA_W-EN_W){1'b0}}, sen}; end
            default:     begin rights = '0;                                      end
        endcase
    end

    assign wr_go   = csr_wr & rights.wr_ok;
    assign wr_full = wr_go & (dec.cls == CLS_MCNT) & ~xlen32;
    assign wr_lo   = wr_go & (dec.cls == CLS_MCNT) & xlen32;
    assign wr_hi   = wr_go & (dec.cls == CLS_MCNT_HI);
    assign wr_men  = wr_go & (dec.cls == CLS_MEN);
    assign wr_sen  = wr_go & (dec.cls == CLS_SEN);

    assign csr_illegal = (csr_rd & ~rights.rd_ok) | (csr_wr & ~rights.wr_ok);
    assign csr_rdata   = (csr_rd & rights.rd_ok) ? value : '0;

    csr_ctr_store #(.CNT_W(DATA_W), .EN_W(EN_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_full (wr_full),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wr_men  (wr_men),
        .wr_sen  (wr_sen),
        .wdata   (csr_wdata),
        .retire  (retire),
        .cnt     (cnt),
        .men     (men),
        .sen     (sen)
    );

    AST_MACHINE_READ_OPEN: assert property (@(posedge clk) disable iff (rst)
        (csr_rd && !csr_wr && dec.cls == CLS_MCNT) |-> !csr_illegal); // R6
    AST_HALF_NEEDS_32: assert property (@(posedge clk) disable iff (rst)
        (csr_rd && !xlen32 && (dec.cls == CLS_MCNT_HI || dec.cls == CLS_UCNT_HI)) |-> csr_illegal); // R5
    AST_DENIED_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        (csr_rd && csr_illegal && !csr_wr) |-> csr_rdata == '0); // R7
    AST_HPM_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (csr_rd && (dec.cls == CLS_UHPM || dec.cls == CLS_MHPM || dec.cls == CLS_EVENT)) |-> csr_rdata == '0); // R8
    AST_USER_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        (csr_wr && (dec.cls == CLS_UCNT || dec.cls == CLS_UHPM)) |-> csr_illegal); // R10
endmodule

// File: tb/csr_ctr_unit_tb.sv
`timescale 1ns/1ps
module csr_ctr_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] csr_addr = '0;
    logic        csr_rd = 1'b0;
    logic        csr_wr = 1'b0;
    logic [63:0] csr_wdata = '0;
    logic        retire = 1'b0;
    logic [1:0]  priv = 2'd3;
    logic        xlen32 = 1'b0;
    logic [63:0] csr_rdata;
    logic        csr_illegal;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [63:0] m_cnt;
    logic [31:0] m_men;
    logic [31:0] m_sen;

    always #4 clk = ~clk;  // 125 MHz

    csr_ctr_unit dut_i (
        .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_rd(csr_rd),
        .csr_wr(csr_wr), .csr_wdata(csr_wdata), .retire(retire),
        .priv(priv), .xlen32(xlen32), .csr_rdata(csr_rdata),
        .csr_illegal(csr_illegal)
    );

    function automatic bit allowed(input logic [4:0] i);
        case (priv)
            2'd3:    return 1'b1;
            2'd0:    return m_men[i] & m_sen[i];
            default: return m_men[i];
        endcase
    endfunction

    function automatic void model_read(input logic [11:0] a, output bit ok, output logic [63:0] v);
        logic [4:0] i;
        logic [63:0] lo;
        bit ctr;
        i = a[4:0];
        ctr = (i == 5'd0) || (i == 5'd2);
        lo = xlen32 ? {32'd0, m_cnt[31:0]} : m_cnt;
        ok = 0;
        v = 0;
        if (a == 12'h306) begin ok = 1; v = {32'd0, m_men}; end
        else if (a == 12'h106) begin ok = 1; v = {32'd0, m_sen}; end
        else if (a >= 12'hC00 && a <= 12'hC1F && i != 5'd1) begin
            ok = allowed(i); v = ctr ? lo : 64'd0;
        end else if (a >= 12'hC80 && a <= 12'hC9F && i != 5'd1) begin
            ok = allowed(i) && xlen32; v = ctr ? {32'd0, m_cnt[63:32]} : 64'd0;
        end else if (a >= 12'hB00 && a <= 12'hB1F && i != 5'd1) begin
            ok = 1; v = ctr ? lo : 64'd0;
        end else if (a >= 12'hB80 && a <= 12'hB9F && i != 5'd1) begin
            ok = xlen32; v = ctr ? {32'd0, m_cnt[63:32]} : 64'd0;
        end else if (a >= 12'h323 && a <= 12'h33F) begin
            ok = 1;
        end
        if (!ok) v = 0;
    endfunction

    function automatic bit model_write_ok(input logic [11:0] a);
        logic [4:0] i;
        i = a[4:0];
        if (a == 12'h306 || a == 12'h106) return 1;
        if (a >= 12'hB00 && a <= 12'hB1F && i != 5'd1) return 1;
        if (a >= 12'hB80 && a <= 12'hB9F && i != 5'd1) return xlen32;
        if (a >= 12'h323 && a <= 12'h33F) return 1;
        return 0;
    endfunction

    task automatic check(input bit cond, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one access cycle; called at a falling edge
    task automatic access(input logic [11:0] a, input bit rd, input bit wr,
                          input logic [63:0] wd, input bit ret, input string req);
        bit rok, wok, ill;
        logic [63:0] ev;
        logic [4:0] i;
        csr_addr = a; csr_rd = rd; csr_wr = wr; csr_wdata = wd; retire = ret;
        #2;
        model_read(a, rok, ev);
        wok = model_write_ok(a);
        ill = (rd && !rok) || (wr && !wok);
        if (rd || wr)
            check(csr_illegal == ill, req, "illegal", {63'd0, csr_illegal}, {63'd0, ill});
        if (rd)
            check(csr_rdata == (rd && rok ? ev : 64'd0), req, "rdata", csr_rdata, ev);
        @(posedge clk);
        i = a[4:0];
        if (wr && wok && (a == 12'hB00 || a == 12'hB02 || a == 12'hB80 || a == 12'hB82 ||
                          (a >= 12'hB00 && a <= 12'hB9F && (i == 5'd0 || i == 5'd2)))) begin
            if (a[7]) m_cnt[63:32] = wd[31:0];
            else if (xlen32) m_cnt[31:0] = wd[31:0];
            else m_cnt = wd;
        end else if (ret) begin
            m_cnt = m_cnt + 64'd1;
        end
        if (wr && wok && a == 12'h306) m_men = wd[31:0];
        if (wr && wok && a == 12'h106) m_sen = wd[31:0];
        @(negedge clk);
        csr_rd = 0; csr_wr = 0; retire = 0;
    endtask

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'h0000_0005; pats[3] = 32'hA5A5_3C3C;
        m_cnt = 0; m_men = 0; m_sen = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset state
        access(12'hB00, 1, 0, 0, 0, "R1");
        access(12'h306, 1, 0, 0, 0, "R1");
        access(12'h106, 1, 0, 0, 0, "R1");

        // R2: retire pulses, with gaps
        for (int k = 0; k < 5; k++) access(12'h000, 0, 0, 0, 1, "R2");
        access(12'h000, 0, 0, 0, 0, "R2");
        access(12'hB02, 1, 0, 0, 0, "R2");
        check(m_cnt == 64'd5, "R2", "model count", m_cnt, 64'd5);

        // R3 and R5: 64-bit write collides with retire
        access(12'hB02, 0, 1, 64'hFFFF_FFFF_FFFF_FFF0, 1, "R3");
        access(12'hB00, 1, 0, 0, 1, "R3");
        access(12'hB00, 1, 0, 0, 0, "R5");
        access(12'hB80, 1, 0, 0, 0, "R5");
        access(12'hC82, 1, 0, 0, 0, "R5");
        access(12'hB82, 0, 1, 64'h1, 0, "R5");
        access(12'hB00, 1, 0, 0, 0, "R5");

        // R4: 32-bit halves; the low write also hits a retire
        xlen32 = 1;
        access(12'hB00, 0, 1, 64'hDEAD_BEEF_1234_5678, 1, "R4");
        access(12'hB80, 1, 0, 0, 0, "R4");
        access(12'hB82, 0, 1, 64'h0000_0000_CAFE_F00D, 1, "R4");
        access(12'hB00, 1, 0, 0, 0, "R4");
        access(12'hB80, 1, 0, 0, 0, "R4");
        access(12'hFFF, 0, 0, 0, 1, "R4");
        access(12'hB02, 1, 0, 0, 0, "R4");
        xlen32 = 0;
        access(12'hB00, 1, 0, 0, 0, "R4");

        // R10: user addresses are read-only
        access(12'hC00, 0, 1, 64'h0, 1, "R10");
        access(12'hC83, 0, 1, 64'h7, 0, "R10");
        access(12'hB00, 1, 0, 0, 0, "R10");

        // R7: unsupported addresses
        access(12'hC01, 1, 0, 0, 0, "R7");
        access(12'hC81, 1, 0, 0, 0, "R7");
        access(12'h7FF, 1, 0, 0, 0, "R7");
        access(12'hB01, 0, 1, 64'h3, 0, "R7");

        // R8: machine performance slots and event selectors
        for (int a = 12'hB03; a <= 12'hB1F; a++) access(a[11:0], 1, 0, 0, 0, "R8");
        for (int a = 12'h320; a <= 12'h33F; a++) access(a[11:0], 1, 0, 0, 0, "R8");
        xlen32 = 1;
        for (int a = 12'hB83; a <= 12'hB9F; a++) access(a[11:0], 1, 0, 0, 0, "R8");
        xlen32 = 0;

        // R9: enable registers and same-cycle increment
        access(12'h306, 0, 1, 64'hFFFF_FFFF_8765_4321, 1, "R9");
        access(12'h306, 1, 0, 0, 0, "R9");
        access(12'h106, 0, 1, 64'h1234_5678_0F0F_F0F0, 1, "R9");
        access(12'h106, 1, 0, 0, 0, "R9");
        access(12'hB00, 1, 0, 0, 0, "R9");

        // R6, R7 and R8: sweep of the user windows
        xlen32 = 1;
        access(12'hB00, 0, 1, 64'h9ABC_DEF0, 0, "R6");
        access(12'hB80, 0, 1, 64'h1234_5678, 0, "R6");
        for (int mi = 0; mi < 4; mi++) begin
            for (int si = 0; si < 4; si++) begin
                priv = 2'd3;
                access(12'h306, 0, 1, {32'd0, pats[mi]}, 0, "R9");
                access(12'h106, 0, 1, {32'd0, pats[si] ^ 32'h0000_00FF}, 0, "R9");
                for (int pv = 0; pv < 4; pv++) begin
                    for (int xm = 0; xm < 2; xm++) begin
                        priv = pv[1:0];
                        xlen32 = xm[0];
                        for (int a = 0; a < 32; a++) begin
                            access(12'hC00 + a[11:0], 1, 0, 0, 0, "R6");
                            access(12'hC80 + a[11:0], 1, 0, 0, 0, "R6");
                        end
                    end
                end
            end
        end
        priv = 2'd0;
        access(12'hB00, 1, 0, 0, 0, "R6");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule